// File: doc/BRIEF.md
# Oversampled UART Receive Engine

This block recovers asynchronous serial characters from a single receive line. The line passes through a two-flop synchroniser. After that the engine takes one sample on each baud tick. The number of ticks per bit is chosen at run time as 16, 8 or 3. Three samples at fixed positions near the middle of each bit are combined by majority vote. This filters out short noise on the line.

A character starts on a falling edge of the idle-high line. The start bit is accepted only if its mid-bit vote still reads low. The engine then shifts in 5 to 9 data bits, least significant first. An optional parity bit follows, then the first stop bit. When the stop bit has been voted, the engine emits a one-cycle pulse. The pulse comes with the data, a parity-error flag and a framing-error flag. A second stop bit is never examined, so the next start bit may follow the first stop bit at once. Dropping the enable abandons any character in progress. No result is produced for that character.

The block suits a system that already makes the baud tick and that keeps the received characters in storage of its own. The configuration inputs are used live. They are expected to stay constant while a character is being received.

Top module: `uart_rx_engine`

## Requirements
- R1: After reset, frame_valid, data, parity_err and frame_err are all 0.
- R2: A character begins only on a tick whose sample is low when the previous tick's sample was high. If the vote of the start bit reads high, the engine produces no frame and goes back to waiting for a falling edge.
- R3: char_size selects the number of data bits: 0, 1, 2, 3 and 4 select 5, 6, 7, 8 and 9 bits, and values 5 to 7 select 9 bits. The first received data bit lands in data[0], and data bits above the character size read 0.
- R4: parity_mode 00 and 11 mean no parity bit and parity_err stays 0. With 01 (even), parity_err is 1 when the XOR of the data bits and the parity bit is 1. With 10 (odd), parity_err is 1 when that XOR is 0.
- R5: frame_err is 1 when the vote of the first stop bit is low. After such a frame, the line must read high on a tick before a new start can be detected.
- R6: os_sel selects the oversampling and the voted samples, counting the detection tick of the start bit as sample 1. Code 00 (and 11) gives 16 samples per bit, voting samples 7, 8 and 9. Code 01 gives 8 per bit, voting 3, 4 and 5. Code 10 gives 3 per bit, voting 1, 2 and 3.
- R7: Each bit value is the majority of its three voted samples, so a disturbance that corrupts one voted sample does not change the bit.
- R8: frame_valid is a one-cycle pulse in the clock after the baud tick that votes the first stop bit. data, parity_err and frame_err change only with that pulse, and they hold their values until the next pulse.
- R9: While enable is low, no frame is produced, and a character in progress is discarded. After enable returns high, a new falling edge is needed to start a character.
- R10: A second stop bit is ignored: a start bit that directly follows the first stop bit is received as the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Receiver enable; low aborts reception |
| rxd | input | 1 | Asynchronous serial input, idle high |
| baud_tick | input | 1 | One-cycle sample strobe at the oversampled rate |
| char_size | input | 3 | Data bit count select (5 to 9) |
| parity_mode | input | 2 | 00/11 none, 01 even, 10 odd |
| os_sel | input | 2 | 00/11 16x, 01 8x, 10 3x oversampling |
| frame_valid | output | 1 | One-cycle pulse when a frame is complete |
| data | output | 9 | Received data, right-aligned |
| parity_err | output | 1 | Parity mismatch for the last frame |
| frame_err | output | 1 | Stop bit low for the last frame |

## Verification
The engine has no parameters, so the bench builds its single form. It generates a baud tick every second clock and switches os_sel among all three rates at run time. At that tick rate the sample positions at 3x, where the start sample is itself voted, come within reach. So does a one-clock glitch that can touch only one voted sample at 16x. Every character size from 5 to 9 data bits appears. Parity is run as none, even and odd, including the 10-bit data-plus-parity case. The bench also covers back-to-back characters, a false start, a low stop bit and an enable drop in mid-character.

// File: rtl/uart_rx_engine.sv
module uart_rx_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       rxd,
  input  logic       baud_tick,
  input  logic [2:0] char_size,
  input  logic [1:0] parity_mode,
  input  logic [1:0] os_sel,
  output logic       frame_valid,
  output logic [8:0] data,
  output logic       parity_err,
  output logic       frame_err
);

  logic       sync1, sync2, line_q;
  logic       busy, va, vb, pacc, pbit;
  logic [3:0] cnt, idx;
  logic [8:0] shreg;

  logic [3:0] wrap, pos_a, pos_b, pos_c, nbits, stop_idx;
  logic       has_par, odd_par, maj;

  always_comb begin
    case (os_sel)
      2'b01:   begin wrap = 4'd7; pos_a = 4'd2; pos_b = 4'd3; pos_c = 4'd4; end
      2'b10:   begin wrap = 4'd2; pos_a = 4'd0; pos_b = 4'd1; pos_c = 4'd2; end
      default: begin wrap = 4'd15; pos_a = 4'd6; pos_b = 4'd7; pos_c = 4'd8; end
    endcase
  end

  assign nbits    = (char_size > 3'd4) ? 4'd9 : {1'b0, char_size} + 4'd5;
  assign has_par  = parity_mode == 2'b01 || parity_mode == 2'b10;
  assign odd_par  = parity_mode == 2'b10;
  assign stop_idx = nbits + {3'b000, has_par} + 4'd1;
  assign maj      = (va & vb) | (va & sync2) | (vb & sync2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1       <= 1'b1;
      sync2       <= 1'b1;
      line_q      <= 1'b0;
      busy        <= 1'b0;
      cnt         <= '0;
      idx         <= '0;
      va          <= 1'b0;
      vb          <= 1'b0;
      pacc        <= 1'b0;
      pbit        <= 1'b0;
      shreg       <= '0;
      frame_valid <= 1'b0;
      data        <= '0;
      parity_err  <= 1'b0;
      frame_err   <= 1'b0;
    end else begin
      sync1       <= rxd;
      sync2       <= sync1;
      frame_valid <= 1'b0;
      if (!enable) begin
        busy   <= 1'b0;
        line_q <= 1'b0;
      end else if (baud_tick) begin
        line_q <= sync2;
        if (!busy) begin
          if (line_q && !sync2) begin
            busy  <= 1'b1;
            cnt   <= 4'd1;
            idx   <= '0;
            va    <= sync2;
            shreg <= '0;
            pacc  <= 1'b0;
            pbit  <= 1'b0;
          end
        end else begin
          cnt <= (cnt == wrap) ? 4'd0 : cnt + 4'd1;
          if (cnt == wrap) idx <= idx + 4'd1;
          if (cnt == pos_a) va <= sync2;
          if (cnt == pos_b) vb <= sync2;
          if (cnt == pos_c) begin
            if (idx == 4'd0) begin
              if (maj) busy <= 1'b0;
            end else if (idx <= nbits) begin
              shreg[idx - 4'd1] <= maj;
              pacc              <= pacc ^ maj;
            end else if (idx < stop_idx) begin
              pbit <= maj;
            end else begin
              busy        <= 1'b0;
              frame_valid <= 1'b1;
              data        <= shreg;
              frame_err   <= ~maj;
              parity_err  <= has_par & ((pacc ^ pbit) != odd_par);
            end
          end
        end
      end
    end
  end

endmodule

module uart_rx_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       baud_tick,
  input logic [2:0] char_size,
  input logic [1:0] parity_mode,
  input logic       frame_valid,
  input logic [8:0] data,
  input logic       parity_err,
  input logic       frame_err
);

  // R8
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  // R8
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(baud_tick));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({data, parity_err, frame_err}) |-> frame_valid);

  // R9
  disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !frame_valid);

  // R3
  five_bit_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && char_size == 3'd0) |-> data[8:5] == 4'd0);

  // R4
  no_parity_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && parity_mode == 2'b00) |-> !parity_err);

endmodule

bind uart_rx_engine uart_rx_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .baud_tick(baud_tick),
  .char_size(char_size), .parity_mode(parity_mode),
  .frame_valid(frame_valid), .data(data),
  .parity_err(parity_err), .frame_err(frame_err)
);

// File: tb/uart_rx_engine_bench.sv
module uart_rx_engine_bench;

  localparam int TD = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       rxd = 1'b1;
  logic       baud_tick = 1'b0;
  logic [2:0] char_size = 3'd3;
  logic [1:0] parity_mode = 2'b00;
  logic [1:0] os_sel = 2'b00;
  logic       frame_valid, parity_err, frame_err;
  logic [8:0] data;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  uart_rx_engine u_uart_rx_engine (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rxd(rxd),
    .baud_tick(baud_tick), .char_size(char_size),
    .parity_mode(parity_mode), .os_sel(os_sel),
    .frame_valid(frame_valid), .data(data),
    .parity_err(parity_err), .frame_err(frame_err)
  );

  always #2.5 clk = ~clk;

  int tdiv = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      tdiv = 0;
      baud_tick <= 1'b0;
    end else begin
      tdiv = (tdiv + 1) % TD;
      baud_tick <= (tdiv == 0);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: a queue of the samples seen since the start edge
  bit   m_s1 = 1'b1, m_s2 = 1'b1, m_prev = 1'b0, m_act = 1'b0;
  bit   m_fv = 1'b0, m_pe = 1'b0, m_fe = 1'b0;
  bit [8:0] m_data = '0;
  bit   q[$];

  function automatic int spb(input logic [1:0] o);
    return (o == 2'b01) ? 8 : (o == 2'b10) ? 3 : 16;
  endfunction

  function automatic int firstpos(input logic [1:0] o);
    return (o == 2'b01) ? 3 : (o == 2'b10) ? 1 : 7;
  endfunction

  function automatic bit vote(input int k);
    int s, f, c;
    s = spb(os_sel);
    f = firstpos(os_sel);
    c = int'(q[k*s+f-1]) + int'(q[k*s+f]) + int'(q[k*s+f+1]);
    return c >= 2;
  endfunction

  always @(posedge clk) begin
    bit samp, b, x;
    int n, k, r, s, nd, np;
    if (!rst_n) begin
      m_s1 = 1'b1; m_s2 = 1'b1; m_prev = 1'b0; m_act = 1'b0;
      m_fv = 1'b0; m_pe = 1'b0; m_fe = 1'b0; m_data = '0;
      q.delete();
    end else begin
      samp = m_s2;
      m_s2 = m_s1;
      m_s1 = rxd;
      m_fv = 1'b0;
      if (!enable) begin
        m_act = 1'b0;
        m_prev = 1'b0;
      end else if (baud_tick) begin
        if (!m_act) begin
          if (m_prev && !samp) begin
            m_act = 1'b1;
            q.delete();
            q.push_back(samp);
          end
        end else begin
          q.push_back(samp);
        end
        m_prev = samp;
        if (m_act) begin
          s  = spb(os_sel);
          nd = (char_size > 4) ? 9 : int'(char_size) + 5;
          np = (parity_mode == 2'b01 || parity_mode == 2'b10) ? 1 : 0;
          n  = q.size();
          k  = (n - 1) / s;
          r  = (n - 1) % s + 1;
          if (r == firstpos(os_sel) + 2) begin
            b = vote(k);
            if (k == 0 && b) m_act = 1'b0;
            else if (k == nd + np + 1) begin
              m_act = 1'b0;
              m_fv = 1'b1;
              m_fe = !b;
              m_data = '0;
              x = 1'b0;
              for (int j = 0; j < nd; j++) begin
                m_data[j] = vote(j + 1);
                x ^= m_data[j];
              end
              if (np == 1) begin
                x ^= vote(nd + 1);
                m_pe = (parity_mode == 2'b10) ? !x : x;
              end else begin
                m_pe = 1'b0;
              end
            end
          end
        end
      end
    end
  end

  // R8 every-clock comparison against the reference
  int cap_n = 0;
  logic [8:0] cap_d[$];
  bit cap_pe[$], cap_fe[$];
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R8 model frame_valid", frame_valid, m_fv);
      if (m_fv) begin
        chk("R3 model data", data, m_data);
        chk("R4 model parity_err", parity_err, m_pe);
        chk("R5 model frame_err", frame_err, m_fe);
      end
      if (frame_valid) begin
        cap_n++;
        cap_d.push_back(data);
        cap_pe.push_back(parity_err);
        cap_fe.push_back(frame_err);
      end
    end
  end

  task automatic clear_caps();
    cap_n = 0;
    cap_d.delete();
    cap_pe.delete();
    cap_fe.delete();
  endtask

  task automatic drive_bit(input bit v, input int clks, input bit glitch);
    if (glitch) begin
      rxd <= v;
      repeat (clks / 2) @(negedge clk);
      rxd <= 1'b0;
      @(negedge clk);
      rxd <= v;
      repeat (clks - clks / 2 - 1) @(negedge clk);
    end else begin
      rxd <= v;
      repeat (clks) @(negedge clk);
    end
  endtask

  task automatic send(input logic [8:0] d, input int nd, input int pm,
                      input bit bad_par, input bit stop_v, input bit glitch0,
                      input int tail_bits);
    int bc;
    bit p;
    bc = spb(os_sel) * TD;
    drive_bit(1'b0, bc, 1'b0);
    p = 1'b0;
    for (int j = 0; j < nd; j++) begin
      drive_bit(d[j], bc, glitch0 && j == 0);
      p ^= d[j];
    end
    if (pm == 1) drive_bit(p ^ bad_par, bc, 1'b0);
    if (pm == 2) drive_bit(~p ^ bad_par, bc, 1'b0);
    drive_bit(stop_v, bc, 1'b0);
    rxd <= 1'b1;
    repeat (tail_bits * bc) @(negedge clk);
  endtask

  task automatic expect_one(input string tag, input logic [8:0] d, input bit pe, input bit fe);
    chk({tag, " frame count"}, cap_n, 1);
    if (cap_n >= 1) begin
      chk({tag, " data"}, cap_d[0], d);
      chk({tag, " parity_err"}, cap_pe[0], pe);
      chk({tag, " frame_err"}, cap_fe[0], fe);
    end
  endtask

  task automatic config_rx(input logic [1:0] o, input logic [2:0] cs, input logic [1:0] pm);
    os_sel <= o;
    char_size <= cs;
    parity_mode <= pm;
    rxd <= 1'b1;
    repeat (80) @(negedge clk);
    clear_caps();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reset frame_valid", frame_valid, 0);
    chk("R1 reset data", data, 0);
    chk("R1 reset parity_err", parity_err, 0);
    chk("R1 reset frame_err", frame_err, 0);
    rst_n <= 1'b1;
    enable <= 1'b1;

    // R6 16x, R3 eight bits no parity
    config_rx(2'b00, 3'd3, 2'b00);
    send(9'h0A5, 8, 0, 0, 1, 0, 2);
    expect_one("R6 16x R3 8N", 9'h0A5, 0, 0);

    // R4 even parity, good then bad
    config_rx(2'b00, 3'd3, 2'b01);
    send(9'h03C, 8, 1, 0, 1, 0, 2);
    expect_one("R4 even good", 9'h03C, 0, 0);
    clear_caps();
    send(9'h03C, 8, 1, 1, 1, 0, 2);
    expect_one("R4 even bad", 9'h03C, 1, 0);

    // R6 8x, R4 odd parity, seven bits
    config_rx(2'b01, 3'd2, 2'b10);
    send(9'h055, 7, 2, 0, 1, 0, 2);
    expect_one("R6 8x R4 7O good", 9'h055, 0, 0);
    clear_caps();
    send(9'h055, 7, 2, 1, 1, 0, 2);
    expect_one("R4 7O bad", 9'h055, 1, 0);

    // R6 3x, R3 five bits
    config_rx(2'b10, 3'd0, 2'b00);
    send(9'h013, 5, 0, 0, 1, 0, 2);
    expect_one("R6 3x R3 5N", 9'h013, 0, 0);

    // R3 six bits and out-of-range size code meaning nine bits
    config_rx(2'b01, 3'd1, 2'b11);
    send(9'h02D, 6, 0, 0, 1, 0, 2);
    expect_one("R3 6N code11", 9'h02D, 0, 0);
    config_rx(2'b00, 3'd7, 2'b01);
    send(9'h1C3, 9, 1, 0, 1, 0, 2);
    expect_one("R3 9E size7", 9'h1C3, 0, 0);

    // R5 low stop bit, then recovery
    config_rx(2'b00, 3'd3, 2'b00);
    send(9'h081, 8, 0, 0, 0, 0, 2);
    expect_one("R5 stop low", 9'h081, 0, 1);
    clear_caps();
    send(9'h07E, 8, 0, 0, 1, 0, 2);
    expect_one("R5 after error", 9'h07E, 0, 0);

    // R2 false start: low for four ticks only
    clear_caps();
    rxd <= 1'b0;
    repeat (4 * TD) @(negedge clk);
    rxd <= 1'b1;
    repeat (40 * 16 * TD) @(negedge clk);
    chk("R2 false start no frame", cap_n, 0);
    send(9'h042, 8, 0, 0, 1, 0, 2);
    expect_one("R2 after false start", 9'h042, 0, 0);

    // R7 one-clock glitch in mid data bit 0
    clear_caps();
    send(9'h0F1, 8, 0, 0, 1, 1, 2);
    expect_one("R7 glitch filtered", 9'h0F1, 0, 0);

    // R9 enable drop mid character
    clear_caps();
    fork
      send(9'h000, 8, 0, 0, 1, 0, 0);
      begin
        repeat (3 * 16 * TD + 5) @(negedge clk);
        enable <= 1'b0;
        repeat (4) @(negedge clk);
        enable <= 1'b1;
      end
    join_any
    disable fork;
    rxd <= 1'b1;
    repeat (20 * 16 * TD) @(negedge clk);
    chk("R9 aborted no frame", cap_n, 0);
    send(9'h099, 8, 0, 0, 1, 0, 2);
    expect_one("R9 after re-enable", 9'h099, 0, 0);

    // R10 back-to-back characters with one stop bit
    clear_caps();
    send(9'h0C3, 8, 0, 0, 1, 0, 0);
    send(9'h05A, 8, 0, 0, 1, 0, 2);
    chk("R10 two frames", cap_n, 2);
    if (cap_n == 2) begin
      chk("R10 first data", cap_d[0], 9'h0C3);
      chk("R10 second data", cap_d[1], 9'h05A);
      chk("R10 second frame_err", cap_fe[1], 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule